// File: doc/BRIEF.md
# Per-Chunk ECC Status Aggregator

During a page read, an error-correction engine reports one status byte for every chunk it has decoded. This block takes that stream of bytes, along with a valid qualifier and two markers that frame the page (first chunk and last chunk). It sorts each byte into one of four classes: clean, corrected, uncorrectable or erased. From those classes it keeps page-level results in registers.

The page-level results are:
- the total number of corrected bits, held in a saturating sum;
- the largest corrected count seen in any single chunk;
- the number of uncorrectable chunks;
- the number of erased chunks;
- a page-fail flag.

The done strobe marks the cycle in which the results for a page are final. An uncorrectable chunk does not stop the page: later chunks still add to the totals. The fail flag takes precedence over the maximum for the page verdict.

Top module: `ecc_chunk_stat_agg`

## Requirements
- R1: After reset all result outputs are zero and `done` is low.
- R2: Status 0x00 (clean) changes no result. Status 0xFF (erased) adds one to `erased_cnt` and nothing else.
- R3: Status 0x01 to 0x28 is a corrected bit count. It is added to `sum_bits`, and `max_bits` becomes the larger of its old value and this count.
- R4: Status 0xFE, and any status from 0x29 to 0xFD, is uncorrectable. It adds one to `uncorr_cnt` and sets `page_fail`. It adds nothing to `sum_bits` or `max_bits`. Chunks after it in the same page are still accumulated.
- R5: An accepted byte with `in_first` high restarts all results. The results then reflect that byte alone.
- R6: `done` is high for exactly the one cycle after the byte carrying `in_last` is accepted. In that cycle the outputs hold the final results for the page.
- R7: `sum_bits` saturates at 0xFFFF instead of wrapping.
- R8: While `in_valid` is low, the status byte and the markers have no effect and all results hold.
- R9: `uncorr_cnt` and `erased_cnt` saturate at their all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Status byte qualifier |
| in_first | input | 1 | Byte belongs to the first chunk of a page |
| in_last | input | 1 | Byte belongs to the last chunk of a page |
| in_stat | input | 8 | Per-chunk status byte |
| done | output | 1 | One-cycle pulse: page results are final |
| sum_bits | output | 16 | Saturating total of corrected bits |
| max_bits | output | 8 | Largest single-chunk corrected count |
| uncorr_cnt | output | 8 | Uncorrectable chunk count |
| erased_cnt | output | 8 | Erased chunk count |
| page_fail | output | 1 | At least one chunk was uncorrectable |

## Verification
The bench targets the code boundaries 0x28, 0x29, 0xFD, 0xFE and 0xFF.
- A classifier that tests the range before checking for the erased code would count erased chunks as failures.
- An off-by-one limit would add 41 bits instead of failing the chunk.

Random pages are interleaved with idle cycles that carry garbage bytes and markers. A design that ignores `in_valid` would corrupt its totals. A design that latches the clear on an idle `in_first` would lose the page.

Long pages of 40-bit chunks and of uncorrectable chunks push the sum and the counts past their limits. A wrapping accumulator would report a small value there. Pages that start right after a failed page check that the fail flag and the counts restart.

// File: rtl/ecc_stat_pkg.sv
package ecc_stat_pkg;
  typedef enum logic [1:0] {
    CLS_CLEAN  = 2'd0,
    CLS_CORR   = 2'd1,
    CLS_UNCORR = 2'd2,
    CLS_ERASED = 2'd3
  } chunk_cls_e;
endpackage

// File: rtl/ecc_stat_classify.sv
module ecc_stat_classify
  import ecc_stat_pkg::*;
#(
  parameter int STAT_W      = 8,
  parameter int MAX_CORR    = 40,
  parameter int ERASED_CODE = 255,
  parameter int UNCORR_CODE = 254
) (
  input  logic [STAT_W-1:0] stat,
  output chunk_cls_e        cls,
  output logic [STAT_W-1:0] corr_bits
);
  localparam logic [STAT_W-1:0] ErasedV = STAT_W'(ERASED_CODE);
  localparam logic [STAT_W-1:0] UncorrV = STAT_W'(UNCORR_CODE);
  localparam logic [STAT_W-1:0] LimitV  = STAT_W'(MAX_CORR);

  always_comb begin
    corr_bits = '0;
    if (stat == '0)           cls = CLS_CLEAN;
    else if (stat == ErasedV) cls = CLS_ERASED;
    else if (stat == UncorrV || stat > LimitV) cls = CLS_UNCORR;
    else begin
      cls       = CLS_CORR;
      corr_bits = stat;
    end
  end
endmodule

// File: rtl/ecc_stat_sat_acc.sv
module ecc_stat_sat_acc #(
  parameter int W     = 16,
  parameter int INC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     q
);
  logic [W-1:0] base;
  logic [W:0]   wide;

  always_comb begin
    base = clr ? '0 : q;
    wide = {1'b0, base} + (W+1)'(inc);
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= wide[W] ? '1 : wide[W-1:0];
  end

  // R7 R9
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && q == '1) |=> q == '1);
  // R8
  acc_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));
endmodule

// File: rtl/ecc_chunk_stat_agg.sv
module ecc_chunk_stat_agg
  import ecc_stat_pkg::*;
#(
  parameter int STAT_W      = 8,
  parameter int SUM_W       = 16,
  parameter int CNT_W       = 8,
  parameter int MAX_CORR    = 40,
  parameter int ERASED_CODE = 255,
  parameter int UNCORR_CODE = 254
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic              in_last,
  input  logic [STAT_W-1:0] in_stat,
  output logic              done,
  output logic [SUM_W-1:0]  sum_bits,
  output logic [STAT_W-1:0] max_bits,
  output logic [CNT_W-1:0]  uncorr_cnt,
  output logic [CNT_W-1:0]  erased_cnt,
  output logic              page_fail
);
  chunk_cls_e        cls;
  logic [STAT_W-1:0] corr_bits;
  logic              is_unc, is_era, clr;

  ecc_stat_classify #(
    .STAT_W(STAT_W), .MAX_CORR(MAX_CORR),
    .ERASED_CODE(ERASED_CODE), .UNCORR_CODE(UNCORR_CODE)
  ) cls_i (.stat(in_stat), .cls(cls), .corr_bits(corr_bits));

  assign is_unc = (cls == CLS_UNCORR);
  assign is_era = (cls == CLS_ERASED);
  assign clr    = in_first;

  ecc_stat_sat_acc #(.W(SUM_W), .INC_W(STAT_W)) sum_i (
    .clk(clk), .rst(rst), .en(in_valid), .clr(clr), .inc(corr_bits), .q(sum_bits));
  ecc_stat_sat_acc #(.W(CNT_W), .INC_W(1)) unc_i (
    .clk(clk), .rst(rst), .en(in_valid), .clr(clr), .inc(is_unc), .q(uncorr_cnt));
  ecc_stat_sat_acc #(.W(CNT_W), .INC_W(1)) era_i (
    .clk(clk), .rst(rst), .en(in_valid), .clr(clr), .inc(is_era), .q(erased_cnt));

  logic [STAT_W-1:0] max_base;
  assign max_base = clr ? '0 : max_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      max_bits  <= '0;
      page_fail <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= in_valid && in_last;
      if (in_valid) begin
        max_bits  <= (corr_bits > max_base) ? corr_bits : max_base;
        page_fail <= (clr ? 1'b0 : page_fail) | is_unc;
      end
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last) |=> done);
  // R6
  done_only_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_last) |=> !done);
  // R4
  fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (page_fail && !(in_valid && in_first)) |=> page_fail);
  // R4
  unc_fail_chk: assert property (@(posedge clk) disable iff (rst)
    (uncorr_cnt != '0) |-> page_fail);
  // R3
  max_limit_chk: assert property (@(posedge clk) disable iff (rst)
    max_bits <= STAT_W'(MAX_CORR));
  // R8
  max_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(max_bits) && $stable(page_fail)));
endmodule

// File: tb/ecc_chunk_stat_agg_tb.sv
module ecc_chunk_stat_agg_tb_top;
  logic clk = 0, rst = 1;
  logic in_valid = 0, in_first = 0, in_last = 0;
  logic [7:0] in_stat = 0;
  logic done, page_fail;
  logic [15:0] sum_bits;
  logic [7:0] max_bits, uncorr_cnt, erased_cnt;

  int n_chk = 0, n_bad = 0;
  int m_sum, m_max, m_unc, m_era;
  bit m_fail;
  int seed = 32'h1234abcd;

  always #2 clk = ~clk;

  ecc_chunk_stat_agg dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_stat(in_stat), .done(done), .sum_bits(sum_bits),
    .max_bits(max_bits), .uncorr_cnt(uncorr_cnt), .erased_cnt(erased_cnt),
    .page_fail(page_fail));

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int sat(input int v, input int lim);
    return (v > lim) ? lim : v;
  endfunction

  task automatic model(input logic [7:0] s, input bit f);
    if (f) begin m_sum = 0; m_max = 0; m_unc = 0; m_era = 0; m_fail = 0; end
    if (s == 8'h00) ;
    else if (s == 8'hFF) m_era = sat(m_era + 1, 255);
    else if (s == 8'hFE || s > 8'h28) begin m_unc = sat(m_unc + 1, 255); m_fail = 1; end
    else begin
      m_sum = sat(m_sum + s, 65535);
      if (s > m_max) m_max = s;
    end
  endtask

  task automatic push(input logic [7:0] s, input bit f, input bit l);
    @(negedge clk);
    in_valid = 1; in_stat = s; in_first = f; in_last = l;
    model(s, f);
  endtask

  task automatic idle_garbage();
    @(negedge clk);
    in_valid = 0; in_stat = 8'($urandom); in_first = 1'($urandom); in_last = 1'($urandom);
  endtask

  task automatic check_all(input string req);
    chk({req, " sum"}, sum_bits, m_sum);
    chk({req, " max"}, max_bits, m_max);
    chk({req, " uncorr"}, uncorr_cnt, m_unc);
    chk({req, " erased"}, erased_cnt, m_era);
    chk({req, " fail"}, page_fail, m_fail);
  endtask

  task automatic finish_page(input string req);
    @(negedge clk);
    in_valid = 0; in_first = 0; in_last = 0;
    chk({req, " R6 done high"}, done, 1);
    check_all(req);
    @(negedge clk);
    chk({req, " R6 done low"}, done, 0);
  endtask

  function automatic logic [7:0] rnd_stat();
    int k = $urandom_range(0, 9);
    case (k)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'hFE;
      3: return 8'($urandom_range(41, 253));
      default: return 8'($urandom_range(1, 40));
    endcase
  endfunction

  task automatic page(input logic [7:0] st[], input string req);
    foreach (st[i]) begin
      push(st[i], i == 0, i == st.size() - 1);
      if ($urandom_range(0, 3) == 0 && i != st.size() - 1) begin
        idle_garbage();
        @(negedge clk);
        check_all("R8 idle hold");
        in_valid = 0;
      end
    end
    finish_page(req);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(seed));
    m_sum = 0; m_max = 0; m_unc = 0; m_era = 0; m_fail = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", done, 0);
    check_all("R1");

    // R2 clean and erased; R3 boundary 0x28; R4 boundaries
    page('{8'h00, 8'hFF, 8'h00, 8'hFF}, "R2");
    chk("R2 erased two", erased_cnt, 2);
    page('{8'h01, 8'h28, 8'h05}, "R3");
    chk("R3 sum 46", sum_bits, 46);
    chk("R3 max 40", max_bits, 40);
    page('{8'h03, 8'h29, 8'h07, 8'hFE, 8'hFD, 8'h02}, "R4");
    chk("R4 uncorr three", uncorr_cnt, 3);
    chk("R4 sum after fail", sum_bits, 12);
    chk("R4 max after fail", max_bits, 7);
    // R5 restart after failed page
    page('{8'h04}, "R5");
    chk("R5 fail cleared", page_fail, 0);
    chk("R5 sum single", sum_bits, 4);
    // R5 first marker mid-stream without last
    push(8'h10, 1, 0); push(8'h20, 0, 0); push(8'h09, 1, 1);
    finish_page("R5 restart");
    chk("R5 restart sum", sum_bits, 9);

    // R7 sum saturation
    for (int i = 0; i < 1700; i++) push(8'h28, i == 0, i == 1699);
    finish_page("R7");
    chk("R7 saturated sum", sum_bits, 65535);
    // R9 count saturation
    for (int i = 0; i < 300; i++) push((i % 2) ? 8'hFE : 8'hFF, i == 0, 0);
    for (int i = 0; i < 300; i++) push(8'h80, 0, i == 299);
    finish_page("R9");
    chk("R9 uncorr sat", uncorr_cnt, 255);
    chk("R9 erased sat", erased_cnt, 150);

    // R8 idle garbage then random pages (R2 R3 R4)
    repeat (5) idle_garbage();
    @(negedge clk);
    check_all("R8 long idle");
    in_valid = 0;
    for (int p = 0; p < 60; p++) begin
      logic [7:0] st[];
      st = new[$urandom_range(1, 16)];
      foreach (st[i]) st[i] = rnd_stat();
      page(st, "random R3 R4");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule